// File: doc/BRIEF.md
# Processor Watchdog and Reset Pulse Generator

This block supervises a processor in two ways. It watches a strobe line that the software toggles periodically; if the strobe shows no edge for a whole timeout window, the active-low fault output drops. It also drives an active-low system reset. A manual request or a low supply flag asserts this reset, and it stays asserted for a fixed stretch after the cause goes away. All periods are counted in clock cycles.

The watchdog is frozen and cleared whenever the supply flag is low, the strobe is marked as floating, or the system reset is asserted. A build-time option routes the fault back into the manual-reset request. With that option, a processor that stops toggling the strobe gets a regular train of reset pulses instead of a fault that stays latched. The strobe goes through a synchroniser before its edges are detected. The other inputs are taken as already synchronous to the clock.

Top module: `wdsup_top`

## Requirements
- R1: A change of the strobe in either direction, rising or falling, is seen by the watchdog three clock edges after it reaches the input: two synchroniser stages and one detect register. The watchdog counter then restarts, and a low fault output returns high (1) after that same edge.
- R2: With the watchdog enabled, the fault output goes low (0) after exactly WD_CYCLES + 3 clock edges with no further strobe change. When the watchdog is enabled from its cleared state with a constant strobe, it goes low after exactly WD_CYCLES edges. It then stays low until a strobe change, a reset or a disable.
- R3: While pwr_ok is 0 or strobe_float is 1, the watchdog does not count, and the fault output is 1 from the next clock edge on.
- R4: While sys_rst_n is 0, the watchdog counter is cleared, and the fault output is 1 from the next clock edge on.
- R5: With FAULT_TO_MR = 1 and a constant strobe, sys_rst_n repeats low pulses. Each pulse is RST_CYCLES + 2 cycles long, and a new pulse starts every WD_CYCLES + RST_CYCLES + 3 cycles.
- R6: man_rst_n = 0 drives sys_rst_n to 0 after the next clock edge. Once man_rst_n is back at 1, sys_rst_n stays 0 for the next RST_CYCLES edges and rises after the following edge.
- R7: pwr_ok = 0 drives sys_rst_n to 0 after the next clock edge. When pwr_ok returns to 1, sys_rst_n is released with the same stretch as in R6.
- R8: While rst_n is 0, sys_rst_n is 0 and wd_fault_n is 1. After rst_n is released, with no request present, sys_rst_n rises after the (RST_CYCLES + 1)-th clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low |
| pwr_ok | input | 1 | Supply good flag; 0 means supply below threshold |
| strobe | input | 1 | Watchdog strobe from the processor, asynchronous |
| strobe_float | input | 1 | 1 when the strobe pin is left unconnected |
| man_rst_n | input | 1 | Manual reset request, active low |
| sys_rst_n | output | 1 | System reset, active low, registered |
| wd_fault_n | output | 1 | Watchdog fault, active low, registered |

## Verification
A stuck or mis-sized watchdog counter shows at wd_fault_n as a fault edge that comes one or more cycles early or late against the WD_CYCLES + 3 window. The bench probes the cycle just before that edge and the cycle on it. A reset-stretch counter that is off by one moves the rising edge of sys_rst_n by one cycle, and the bench checks both sides of that edge. A missing clear path (reset or disable not clearing the watchdog) leaves wd_fault_n low one cycle after the cause, or breaks the period of the pulse train in the feedback build. Either shows within a single window.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

    // Phases of the reset pulse generator
    typedef enum logic [1:0] {
        RG_RUN     = 2'd0,  // reset released
        RG_HELD    = 2'd1,  // a request is active
        RG_STRETCH = 2'd2   // request gone, timing out the pulse
    } rg_phase_e;

    // Bits needed to hold the values 0..n
    function automatic int cnt_bits(input int n);
        if (n < 2) begin
            return 1;
        end
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wdsup_sync.sv
module wdsup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_pulse
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < STAGES; i++) begin
            if (i == 0) begin
                st_d.chain[i] = din;
            end else begin
                st_d.chain[i] = st_q.chain[i-1];
            end
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_pulse = st_q.chain[STAGES-1] ^ st_q.prev;

endmodule

// File: rtl/wdsup_wdog.sv
module wdsup_wdog
    import wdsup_pkg::*;
#(
    parameter int WD_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clear,
    input  logic strobe_edge,
    output logic fault
);
    localparam int CW = cnt_bits(WD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fault;
    } wd_st_t;

    wd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable || clear) begin
            st_d.cnt   = '0;
            st_d.fault = 1'b0;
        end else if (strobe_edge) begin
            st_d.cnt   = '0;
            st_d.fault = 1'b0;
        end else if (st_q.fault) begin
            st_d.cnt   = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt   = '0;
            st_d.fault = 1'b1;
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault = st_q.fault;

endmodule

// File: rtl/wdsup_rstgen.sv
module wdsup_rstgen
    import wdsup_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic request,
    output logic asserted
);
    localparam int CW = cnt_bits(RST_CYCLES);
    localparam logic [CW-1:0] FULL = CW'(RST_CYCLES);

    typedef struct packed {
        rg_phase_e     phase;
        logic [CW-1:0] cnt;
    } rg_st_t;

    rg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (request) begin
            st_d.phase = RG_HELD;
            st_d.cnt   = FULL;
        end else begin
            case (st_q.phase)
                RG_HELD: begin
                    st_d.phase = RG_STRETCH;
                    st_d.cnt   = FULL - 1'b1;
                end
                RG_STRETCH: begin
                    if (st_q.cnt == '0) begin
                        st_d.phase = RG_RUN;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                default: begin
                    st_d.phase = RG_RUN;
                    st_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= RG_HELD;
            st_q.cnt   <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign asserted = (st_q.phase != RG_RUN);

endmodule

// File: rtl/wdsup_top.sv
module wdsup_top #(
    parameter int WD_CYCLES   = 64,
    parameter int RST_CYCLES  = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit FAULT_TO_MR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic strobe,
    input  logic strobe_float,
    input  logic man_rst_n,
    output logic sys_rst_n,
    output logic wd_fault_n
);
    logic strobe_edge;
    logic fault;
    logic rst_asserted;
    logic mr_eff_n;
    logic wd_enable;
    logic rst_request;

    wdsup_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (strobe),
        .edge_pulse (strobe_edge)
    );

    generate
        if (FAULT_TO_MR) begin : g_fb
            assign mr_eff_n = man_rst_n & ~fault;
        end else begin : g_nofb
            assign mr_eff_n = man_rst_n;
        end
    endgenerate

    assign wd_enable   = pwr_ok & ~strobe_float;
    assign rst_request = ~mr_eff_n | ~pwr_ok;

    wdsup_wdog #(
        .WD_CYCLES (WD_CYCLES)
    ) u_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (wd_enable),
        .clear       (rst_asserted),
        .strobe_edge (strobe_edge),
        .fault       (fault)
    );

    wdsup_rstgen #(
        .RST_CYCLES (RST_CYCLES)
    ) u_rstgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .request  (rst_request),
        .asserted (rst_asserted)
    );

    assign sys_rst_n  = ~rst_asserted;
    assign wd_fault_n = ~fault;

endmodule

// File: rtl/wdsup_chk.sv
module wdsup_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok,
    input logic strobe_float,
    input logic mr_eff_n,
    input logic strobe_edge,
    input logic sys_rst_n,
    input logic wd_fault_n
);
    // R1: a detected strobe edge on an enabled, running watchdog leaves the fault high
    a_r1_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_edge && pwr_ok && !strobe_float && sys_rst_n) |=> wd_fault_n);

    // R2: a fault can only appear after a cycle that saw no strobe edge
    a_r2_fault_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_fault_n) |-> !$past(strobe_edge));

    // R3: a disabled watchdog shows no fault
    a_r3_disabled_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_ok || strobe_float) |=> wd_fault_n);

    // R4: an asserted system reset clears the fault
    a_r4_reset_clears_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |=> wd_fault_n);

    // R6: a manual request asserts reset on the next edge
    a_r6_manual_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_eff_n |=> !sys_rst_n);

    // R7: a low supply asserts reset on the next edge
    a_r7_supply_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !sys_rst_n);

    // R6: release only after a cycle with no request present
    a_r6_release_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> ($past(mr_eff_n) && $past(pwr_ok)));

endmodule

bind wdsup_top wdsup_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_ok       (pwr_ok),
    .strobe_float (strobe_float),
    .mr_eff_n     (mr_eff_n),
    .strobe_edge  (strobe_edge),
    .sys_rst_n    (sys_rst_n),
    .wd_fault_n   (wd_fault_n)
);

// File: tb/tb_wdsup_top.sv
module tb_wdsup_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD  = 16;
    localparam int RST = 4;
    localparam int NV  = 8;

    // {gap in cycles after a strobe toggle, 1 = fault expected at the end}
    localparam logic [8:0] VEC [NV] = '{
        {8'd4,         1'b0},
        {8'(WD + 2),   1'b0},
        {8'(WD + 3),   1'b1},
        {8'd10,        1'b0},
        {8'(WD + 3),   1'b1},
        {8'(WD + 2),   1'b0},
        {8'd3,         1'b0},
        {8'(WD + 8),   1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1;
    logic strobe = 1'b0;
    logic strobe_float = 1'b0;
    logic man_rst_n = 1'b1;
    logic sys_rst_n, wd_fault_n;
    logic loop_rst_n, loop_fault_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdsup_top #(.WD_CYCLES(WD), .RST_CYCLES(RST), .FAULT_TO_MR(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .strobe(strobe),
        .strobe_float(strobe_float), .man_rst_n(man_rst_n),
        .sys_rst_n(sys_rst_n), .wd_fault_n(wd_fault_n));

    wdsup_top #(.WD_CYCLES(WD), .RST_CYCLES(RST), .FAULT_TO_MR(1'b1)) dut_loop (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .strobe(1'b0),
        .strobe_float(1'b0), .man_rst_n(1'b1),
        .sys_rst_n(loop_rst_n), .wd_fault_n(loop_fault_n));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lowc;
        int per;
        bit prev;
        bit seen;
        bit inlow;

        // R8: reset state
        step(3);
        chk("R8 reset sys_rst_n", sys_rst_n, 0);
        chk("R8 reset wd_fault_n", wd_fault_n, 1);
        chk("R8 reset loop wd_fault_n", loop_fault_n, 1);
        rst_n = 1'b1;
        step(RST);
        chk("R8 still held", sys_rst_n, 0);
        step(1);
        chk("R8 released", sys_rst_n, 1);

        // R1/R2: table of strobe gaps
        for (int v = 0; v < NV; v++) begin
            strobe = ~strobe;
            step(int'(VEC[v][8:1]));
            chk(VEC[v][0] ? "R2 fault after quiet window" : "R1 edge keeps fault high",
                wd_fault_n, VEC[v][0] ? 0 : 1);
        end
        strobe = ~strobe;
        step(3);
        chk("R1 edge clears fault", wd_fault_n, 1);

        // R6: manual reset
        man_rst_n = 1'b0;
        step(1);
        chk("R6 manual asserts", sys_rst_n, 0);
        step(3);
        man_rst_n = 1'b1;
        step(RST);
        chk("R6 stretch held", sys_rst_n, 0);
        step(1);
        chk("R6 released", sys_rst_n, 1);

        // R4: reset clears fault
        step(WD + 4);
        chk("R2 fault before reset", wd_fault_n, 0);
        man_rst_n = 1'b0;
        step(2);
        chk("R4 reset clears fault", wd_fault_n, 1);
        man_rst_n = 1'b1;
        step(RST + 2);
        chk("R6 released again", sys_rst_n, 1);

        // R3: floating strobe
        step(2 * WD + 8);
        chk("R2 fault before float", wd_fault_n, 0);
        strobe_float = 1'b1;
        step(1);
        chk("R3 float clears fault", wd_fault_n, 1);
        step(3 * WD);
        chk("R3 float keeps fault high", wd_fault_n, 1);
        chk("R3 float no reset", sys_rst_n, 1);
        strobe_float = 1'b0;
        step(WD - 1);
        chk("R2 enable window not yet", wd_fault_n, 1);
        step(1);
        chk("R2 enable window expired", wd_fault_n, 0);

        // R7: supply low
        pwr_ok = 1'b0;
        step(1);
        chk("R7 supply low asserts", sys_rst_n, 0);
        chk("R3 supply low clears fault", wd_fault_n, 1);
        step(3 * WD);
        chk("R3 supply low fault high", wd_fault_n, 1);
        chk("R7 supply low held", sys_rst_n, 0);
        pwr_ok = 1'b1;
        step(RST);
        chk("R7 stretch held", sys_rst_n, 0);
        step(1);
        chk("R7 released", sys_rst_n, 1);

        // R5: feedback pulse train
        seen = 1'b0;
        for (int i = 0; i < 500 && !seen; i++) begin
            prev = loop_rst_n;
            step(1);
            if (prev && !loop_rst_n) seen = 1'b1;
        end
        chk("R5 pulse seen", int'(seen), 1);
        lowc = 1;
        per = 0;
        inlow = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 500 && !seen; i++) begin
            prev = loop_rst_n;
            step(1);
            per++;
            if (!loop_rst_n) begin
                if (prev) seen = 1'b1;
                else if (inlow) lowc++;
            end else begin
                inlow = 1'b0;
            end
        end
        chk("R5 pulse width", lowc, RST + 2);
        chk("R5 pulse period", per, WD + RST + 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule